// File: doc/BRIEF.md
# Background and Window Tile Fetch Address Generator

This block works out, for one screen pixel per cycle, which memory bytes a tile renderer must read. It picks the layer that covers the pixel. That layer is either the scrolled 256x256 background, which wraps at its edges, or the fixed window, which covers everything to the right of and below its corner. From that layer's coordinates it forms the address of the tile-map byte. From the tile number that the caller supplies, it forms the address of the pattern row.

The window has its own row counter. This counter is cleared at the start of a frame and advances only after a line on which the window covered at least one pixel. If the window is switched off partway down the screen and later switched on again, it continues with the row where it stopped. Every result is registered, so the outputs appear one cycle after the inputs.

Top module: `bgwin_fetch_addr`

## Requirements
- R1: While reset is high and in the first cycle after reset, valid_o, layer_on_o and win_sel_o are 0, both address outputs are 0, and the window row counter is 0.
- R2: When the background covers a pixel, the layer row is (line + scroll_y) mod 256 and the layer column is (col + scroll_x) mod 256. The map address is then base + (row/8)*32 + column/8, where base is 0x9800, or 0x9C00 when bg_map_hi_i is 1.
- R3: With tile_unsigned_i = 1, the pattern address is 0x8000 + index*16 + (row mod 8)*2, with the index taken as unsigned 0..255.
- R4: With tile_unsigned_i = 0, the pattern address is 0x9000 + index*16 + (row mod 8)*2, with the index taken as signed -128..127.
- R5: The window covers a pixel when win_en_i is 1, win_x_i <= 166, line >= win_y_i and col + 7 >= win_x_i. The layer column is then col + 7 - win_x_i and the layer row is the window row counter. The map base is 0x9800, or 0x9C00 when win_map_hi_i is 1, and win_sel_o is 1.
- R6: A frame_start pulse clears the window row counter. A line_end pulse adds one to it only if the window covered a pixel while pix_valid was high on that line. Disabling the window partway through a frame therefore leaves the row value in place for when the window resumes.
- R7: A win_x_i value above 166 hides the window exactly as win_en_i = 0 does, and the background is shown in its place.
- R8: When neither layer covers a pixel, layer_on_o and win_sel_o are 0 and both addresses are 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge, and valid_o repeats pix_valid with one cycle of delay.
- R10: The window covers a pixel even when bg_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A pixel position is presented this cycle |
| frame_start | input | 1 | Pulse at the start of a frame |
| line_end | input | 1 | Pulse after the last pixel of a line |
| line_i | input | 8 | Current screen line |
| col_i | input | 8 | Current screen column |
| scroll_x_i | input | 8 | Background horizontal scroll |
| scroll_y_i | input | 8 | Background vertical scroll |
| win_x_i | input | 8 | Window corner X plus 7 |
| win_y_i | input | 8 | Window corner Y |
| bg_en_i | input | 1 | Background enable |
| win_en_i | input | 1 | Window enable |
| tile_unsigned_i | input | 1 | 1: unsigned indices from 0x8000; 0: signed indices from 0x9000 |
| bg_map_hi_i | input | 1 | Background map at 0x9C00 instead of 0x9800 |
| win_map_hi_i | input | 1 | Window map at 0x9C00 instead of 0x9800 |
| tile_idx_i | input | 8 | Tile number read for this pixel |
| valid_o | output | 1 | Outputs belong to a valid pixel |
| map_addr_o | output | 16 | Tile-map byte address |
| pat_addr_o | output | 16 | Pattern row address (low byte of the row) |
| layer_on_o | output | 1 | Some layer covers the pixel |
| win_sel_o | output | 1 | The window covers the pixel |

## Verification
Several properties are checked on every cycle. The window row counter is cleared after a frame start, never steps by more than one, and stays fixed between line ends. Any covered pixel gets an even pattern address inside the tile data area and a map address inside the map area. Blank pixels carry zero addresses, and the window flag appears only after an enable with an in-range X. Some behaviour can only be shown by the bench scenarios against its model: the exact wrap of the scroll sums, the signed index arithmetic, and the window row resuming correctly after it is disabled by its enable bit or by a large X.

// File: rtl/tile_fetch_pkg.sv
package tile_fetch_pkg;
  parameter int CW          = 8;    // coordinate width
  parameter int AW          = 16;   // address width
  parameter int FINE_W      = 3;    // log2 of tile edge in pixels
  parameter int MAP_COL_W   = 5;    // log2 of map columns
  parameter int TILE_SH     = 4;    // log2 of bytes per tile
  parameter int ROW_SH      = 1;    // log2 of bytes per pixel row
  parameter int WX_OFFSET   = 7;
  parameter int WX_LIMIT    = 166;
  parameter logic [AW-1:0] MAP_LO    = 16'h9800;
  parameter logic [AW-1:0] MAP_HI    = 16'h9C00;
  parameter logic [AW-1:0] TILE_UBAS = 16'h8000;
  parameter logic [AW-1:0] TILE_SBAS = 16'h9000;

  typedef struct packed {
    logic          on;
    logic          win;
    logic [CW-1:0] row;
    logic [CW-1:0] colx;
  } cover_t;
endpackage

// File: rtl/win_line_ctr.sv
module win_line_ctr
  import tile_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          line_end,
  input  logic          drew_now,
  output logic [CW-1:0] cnt
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (line_end) begin
      if (seen || drew_now) cnt <= cnt + 1'b1;
      seen <= 1'b0;
    end else if (drew_now) begin
      seen <= 1'b1;
    end
  end

  // R6: counter cleared by a frame start
  a_r6_clear_on_frame: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> cnt == '0);
  // R6: steps at most by one
  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
  // R6: no change between line ends
  a_r6_hold_midline: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !line_end) |=> $stable(cnt));
endmodule

// File: rtl/layer_select.sv
module layer_select
  import tile_fetch_pkg::*;
(
  input  logic          bg_en,
  input  logic          win_en,
  input  logic [CW-1:0] scx,
  input  logic [CW-1:0] scy,
  input  logic [CW-1:0] wx,
  input  logic [CW-1:0] wy,
  input  logic [CW-1:0] line,
  input  logic [CW-1:0] col,
  input  logic [CW-1:0] wline,
  output cover_t        cov
);
  logic [CW:0] col_sh;
  logic [CW:0] wdiff;
  logic        wx_ok;
  logic        win_on;

  always_comb begin
    col_sh = {1'b0, col} + (CW+1)'(WX_OFFSET);
    wdiff  = col_sh - {1'b0, wx};
    wx_ok  = (wx <= CW'(WX_LIMIT));
    win_on = win_en && wx_ok && (line >= wy) && (col_sh >= {1'b0, wx});
    cov    = '0;
    if (win_on) begin
      cov.on   = 1'b1;
      cov.win  = 1'b1;
      cov.row  = wline;
      cov.colx = wdiff[CW-1:0];
    end else if (bg_en) begin
      cov.on   = 1'b1;
      cov.row  = line + scy;
      cov.colx = col + scx;
    end
  end
endmodule

// File: rtl/addr_calc.sv
module addr_calc
  import tile_fetch_pkg::*;
(
  input  cover_t        cov,
  input  logic          bg_map_hi,
  input  logic          win_map_hi,
  input  logic          tile_unsigned,
  input  logic [CW-1:0] tile,
  output logic [AW-1:0] map_addr,
  output logic [AW-1:0] pat_addr
);
  localparam int TR_W = CW - FINE_W;

  logic [AW-1:0]     map_base;
  logic [AW-1:0]     idx_ext;
  logic [FINE_W-1:0] fine;
  logic [TR_W-1:0]   trow;
  logic [TR_W-1:0]   tcol;

  always_comb begin
    map_base = (cov.win ? win_map_hi : bg_map_hi) ? MAP_HI : MAP_LO;
    trow     = cov.row[CW-1:FINE_W];
    tcol     = cov.colx[CW-1:FINE_W];
    fine     = cov.row[FINE_W-1:0];
    idx_ext  = tile_unsigned ? AW'(tile) : AW'($signed(tile));
    if (cov.on) begin
      map_addr = map_base + (AW'(trow) << MAP_COL_W) + AW'(tcol);
      pat_addr = (tile_unsigned ? TILE_UBAS : TILE_SBAS)
               + (idx_ext << TILE_SH) + (AW'(fine) << ROW_SH);
    end else begin
      map_addr = '0;
      pat_addr = '0;
    end
  end
endmodule

// File: rtl/bgwin_fetch_addr.sv
module bgwin_fetch_addr
  import tile_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_valid,
  input  logic          frame_start,
  input  logic          line_end,
  input  logic [7:0]    line_i,
  input  logic [7:0]    col_i,
  input  logic [7:0]    scroll_x_i,
  input  logic [7:0]    scroll_y_i,
  input  logic [7:0]    win_x_i,
  input  logic [7:0]    win_y_i,
  input  logic          bg_en_i,
  input  logic          win_en_i,
  input  logic          tile_unsigned_i,
  input  logic          bg_map_hi_i,
  input  logic          win_map_hi_i,
  input  logic [7:0]    tile_idx_i,
  output logic          valid_o,
  output logic [15:0]   map_addr_o,
  output logic [15:0]   pat_addr_o,
  output logic          layer_on_o,
  output logic          win_sel_o
);
  logic [CW-1:0] wline;
  cover_t        cov;
  logic [AW-1:0] map_nxt;
  logic [AW-1:0] pat_nxt;

  win_line_ctr u_wctr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_end(line_end),
    .drew_now(pix_valid && cov.win), .cnt(wline)
  );

  layer_select u_sel (
    .bg_en(bg_en_i), .win_en(win_en_i), .scx(scroll_x_i), .scy(scroll_y_i),
    .wx(win_x_i), .wy(win_y_i), .line(line_i), .col(col_i), .wline(wline),
    .cov(cov)
  );

  addr_calc u_addr (
    .cov(cov), .bg_map_hi(bg_map_hi_i), .win_map_hi(win_map_hi_i),
    .tile_unsigned(tile_unsigned_i), .tile(tile_idx_i),
    .map_addr(map_nxt), .pat_addr(pat_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o    <= 1'b0;
      map_addr_o <= '0;
      pat_addr_o <= '0;
      layer_on_o <= 1'b0;
      win_sel_o  <= 1'b0;
    end else begin
      valid_o    <= pix_valid;
      map_addr_o <= map_nxt;
      pat_addr_o <= pat_nxt;
      layer_on_o <= cov.on;
      win_sel_o  <= cov.win;
    end
  end

  // R9: valid follows pix_valid by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> valid_o);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !valid_o);
  // R5, R7: window flag only after an enable with X in range
  a_r7_win_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ##1 win_sel_o |-> ($past(win_en_i) && $past(win_x_i) <= 8'd166));
  // R8: blank pixels carry zero addresses and no window flag
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (rst)
    !layer_on_o |-> (map_addr_o == '0 && pat_addr_o == '0 && !win_sel_o));
  // R2: map address inside the map area
  a_r2_map_range: assert property (@(posedge clk) disable iff (rst)
    layer_on_o |-> (map_addr_o >= 16'h9800 && map_addr_o <= 16'h9FFF));
  // R3, R4: pattern address even and inside the tile data area
  a_r3_pat_range: assert property (@(posedge clk) disable iff (rst)
    layer_on_o |-> (pat_addr_o[0] == 1'b0 && pat_addr_o >= 16'h8000
                    && pat_addr_o <= 16'h97FF));
endmodule

// File: tb/bgwin_fetch_addr_tb_top.sv
module bgwin_fetch_addr_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pv = 0, fs = 0, le = 0;
  logic [7:0] line = 0, col = 0, scx = 0, scy = 0, wx = 0, wy = 0, tile = 0;
  logic bg_en = 0, win_en = 0, tu = 1, bg_hi = 0, win_hi = 0;
  logic v_o, on_o, w_o;
  logic [15:0] map_o, pat_o;

  int tests = 0;
  int fails = 0;
  int wcnt = 0;
  bit seen = 0;

  always #5 clk = ~clk;

  bgwin_fetch_addr dut_i (
    .clk(clk), .rst(rst), .pix_valid(pv), .frame_start(fs), .line_end(le),
    .line_i(line), .col_i(col), .scroll_x_i(scx), .scroll_y_i(scy),
    .win_x_i(wx), .win_y_i(wy), .bg_en_i(bg_en), .win_en_i(win_en),
    .tile_unsigned_i(tu), .bg_map_hi_i(bg_hi), .win_map_hi_i(win_hi),
    .tile_idx_i(tile), .valid_o(v_o), .map_addr_o(map_o), .pat_addr_o(pat_o),
    .layer_on_o(on_o), .win_sel_o(w_o)
  );

  // one cycle with the current inputs; model computes what the next edge gives
  task automatic cyc(string req);
    bit w, on;
    int row, colx, base, idx, em, ep;
    w  = win_en && (wx <= 166) && (line >= wy) && (int'(col) + 7 >= int'(wx));
    on = w || bg_en;
    if (w) begin
      row = wcnt; colx = int'(col) + 7 - int'(wx);
    end else begin
      row = (int'(line) + int'(scy)) % 256; colx = (int'(col) + int'(scx)) % 256;
    end
    base = (w ? win_hi : bg_hi) ? 'h9C00 : 'h9800;
    idx  = tu ? int'(tile) : (tile >= 128 ? int'(tile) - 256 : int'(tile));
    em   = on ? base + (row / 8) * 32 + colx / 8 : 0;
    ep   = on ? (((tu ? 'h8000 : 'h9000) + idx * 16 + (row % 8) * 2) & 'hFFFF) : 0;
    if (fs) begin wcnt = 0; seen = 0; end
    else if (le) begin
      if (seen || (pv && w)) wcnt = (wcnt + 1) % 256;
      seen = 0;
    end else if (pv && w) seen = 1;
    begin
      bit ev = pv;
      @(posedge clk);
      @(negedge clk);
      tests++;
      if (v_o !== ev || on_o !== on || w_o !== w || map_o !== 16'(em) || pat_o !== 16'(ep)) begin
        fails++;
        $display("FAIL %s: v=%b on=%b win=%b map=%h pat=%h exp v=%b on=%b win=%b map=%h pat=%h",
                 req, v_o, on_o, w_o, map_o, pat_o, ev, on, w, 16'(em), 16'(ep));
      end
    end
  endtask

  task automatic end_line(string req);
    pv = 0; le = 1; cyc(req); le = 0;
  endtask

  task automatic run_line(int ln, int step, string req);
    line = 8'(ln);
    for (int c = 0; c < 160; c += step) begin
      pv = 1; col = 8'(c); tile = 8'((c * 7 + ln * 13) & 255);
      cyc(req);
    end
    end_line(req);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1: reset state
    tests++;
    if (v_o !== 0 || on_o !== 0 || w_o !== 0 || map_o !== 0 || pat_o !== 0) begin
      fails++;
      $display("FAIL R1: v=%b on=%b win=%b map=%h pat=%h exp all zero", v_o, on_o, w_o, map_o, pat_o);
    end
    rst = 0;
    pv = 0; cyc("R1");

    // R2, R3: scrolled background with wrap, unsigned tiles, both map bases
    bg_en = 1; tu = 1; scx = 200; scy = 250;
    for (int ln = 0; ln < 4; ln++) run_line(ln, 1, "R2");
    bg_hi = 1; scx = 3; scy = 9;
    for (int ln = 100; ln < 103; ln++) run_line(ln, 3, "R3");

    // R4: signed tiles, boundary indices
    tu = 0; bg_hi = 0; line = 5;
    foreach (tile[i]) ;
    for (int k = 0; k < 6; k++) begin
      pv = 1; col = 8'(k * 10);
      tile = (k == 0) ? 8'h00 : (k == 1) ? 8'h7F : (k == 2) ? 8'h80 :
             (k == 3) ? 8'hFF : (k == 4) ? 8'h01 : 8'hC3;
      cyc("R4");
    end
    for (int ln = 40; ln < 42; ln++) run_line(ln, 2, "R4");

    // R5, R6, R7: window frame with mid-frame disable by enable and by large X
    tu = 1; pv = 0; fs = 1; cyc("R6"); fs = 0;
    win_en = 1; wy = 4; wx = 87; win_hi = 1; scx = 17; scy = 33;
    for (int ln = 0; ln < 8; ln++) run_line(ln, 4, "R5");
    win_en = 0;
    for (int ln = 8; ln < 11; ln++) run_line(ln, 4, "R6");
    win_en = 1; wx = 167;
    for (int ln = 11; ln < 13; ln++) run_line(ln, 4, "R7");
    wx = 0;
    for (int ln = 13; ln < 22; ln++) run_line(ln, 5, "R6");
    wx = 166;
    for (int ln = 22; ln < 24; ln++) run_line(ln, 1, "R5");

    // R6: new frame restarts window rows
    pv = 0; fs = 1; cyc("R6"); fs = 0;
    wx = 7; wy = 0;
    for (int ln = 0; ln < 3; ln++) run_line(ln, 8, "R6");

    // R10: window shown with background off
    bg_en = 0; tu = 0;
    for (int ln = 3; ln < 5; ln++) run_line(ln, 6, "R10");

    // R8: nothing enabled, and window hidden by position
    win_en = 0;
    run_line(60, 9, "R8");
    win_en = 1; wy = 200;
    run_line(61, 9, "R8");

    // R9: idle cycles with valid low
    pv = 0;
    for (int k = 0; k < 4; k++) cyc("R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule